// File: doc/BRIEF.md
# Four-Lane NAND Flash Read Model

This block models four 8-bit NAND flash devices that run in lock-step behind one 32-bit host bus. Byte lane c of every host word belongs to device c. The host reaches the devices through three windows on a single request channel: a command window, an address window and a data window. Each lane keeps its own command byte, its own byte address and its own read offset. A data read fetches one byte from every device at once and packs the four bytes into one response word. Each lane that is in a read command then steps its offset forward by one.

Device contents live in an internal byte array per lane, `DEPTH` bytes deep. A separate preload port fills the array before or between host accesses. A page holds 528 bytes: 512 data bytes followed by 16 spare bytes. A block holds 256 pages. The command picks where reading starts inside the page: the first half, the second half or the spare area. Program, erase, ID and status commands are accepted and kept, but they change nothing. Lanes that are not reading return a fixed status byte.

Host requests use a valid/ready channel. A request is taken on a clock edge where `hreq_valid` and `hreq_ready` are both high. Every accepted read produces exactly one response on the next cycle. A response stays valid, with its data unchanged, until the host takes it with `hrsp_ready`. While a response is waiting, `hreq_ready` is low, so the host is back-pressured and no new request is taken.

Top module: `nand_quad_model`

## Requirements
- R1: After reset, no response is pending, `hreq_ready` is high, and every lane holds a non-read command, so a data read returns 0xC0C0C0C0.
- R2: A write to the command window (window code 1) gives lane c the byte in bits 8c+7:8c. Command 0x00 sets that lane's read offset to 0, command 0x01 sets it to 256, and command 0x50 sets it to 512.
- R3: Commands 0x90, 0xFF, 0x80, 0x60, 0x70, 0x10 and 0xD0 are stored but leave the offset alone. Any other byte is stored as 0xFF.
- R4: On a data read (window code 0), a lane whose stored command is 0x50 or lower returns the byte at (address + offset). That lane's offset then grows by one. Any other lane returns 0xC0 and keeps its offset.
- R5: Writes to the address window (window code 2) build each lane's address in steps. The first write sets the address to the column byte. The second write adds page × 528. The third write adds block × 135168. A command write restarts this sequence, and address writes after the third one are ignored.
- R6: In a response word, lane 3's byte sits in bits 31:24 and lane 0's byte sits in bits 7:0.
- R7: The byte index into a lane's array is (address + offset) modulo `DEPTH`.
- R8: A request is accepted when `hreq_valid` and `hreq_ready` are both high, and `hreq_ready` is low exactly while a response is pending. The response to an accepted read is valid on the next cycle and holds its data until it is taken with `hrsp_ready`.
- R9: Writes never produce a response. Writes to the data window or to window code 3 have no effect. Reads of any window other than the data window return 0 and move no offset.
- R10: When `pre_we` is high on a clock edge, `pre_data` is written into lane `pre_lane`'s array at index `pre_addr`. Later data reads return that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hreq_valid | input | 1 | Host request valid |
| hreq_ready | output | 1 | Request can be accepted |
| hreq_write | input | 1 | 1 for a write, 0 for a read |
| hreq_win | input | 2 | Window: 0 data, 1 command, 2 address, 3 unused |
| hreq_wdata | input | 32 | Write data, one byte per lane |
| hrsp_valid | output | 1 | Read response valid |
| hrsp_ready | input | 1 | Host takes the response |
| hrsp_data | output | 32 | Packed read data, lane 3 in the top byte |
| pre_we | input | 1 | Preload write strobe |
| pre_lane | input | 2 | Lane to preload |
| pre_addr | input | $clog2(DEPTH) | Byte index to preload |
| pre_data | input | 8 | Byte to preload |

## Verification
The bench aims at four kinds of mistake.

First, lanes can drift apart. It loads mixed per-lane commands and checks that each lane reads from its own area, while a lane with a non-read command shows 0xC0 and does not advance. A design that shared one offset across lanes, or stepped idle lanes, would return the wrong bytes.

Second, the address steps can be miscounted. The bench sends a fourth address write and then restarts the sequence with a command. If the step counter were not cleared by a command, or did not stop after the third write, the address would be corrupted.

Third, stored commands can be handled wrongly. Command 0x10 sits below the read limit, and an unknown code must become 0xFF. A design that reset the offset on every command, or stored an unknown code as it came, would return the wrong data or a data byte instead of status.

Fourth, held responses and wrap-around addresses are exercised. A response is stalled under back-pressure, and addresses run past `DEPTH`. A design that dropped, repeated or changed a stalled response, or that did not wrap the index, would be caught by the cycle-by-cycle reference comparison.

// File: rtl/nqf_pkg.sv
package nqf_pkg;
  localparam int LANES           = 4;
  localparam int LANE_W          = $clog2(LANES);
  localparam int PAGE_DATA       = 512;
  localparam int PAGE_SPARE      = 16;
  localparam int PAGE_BYTES      = PAGE_DATA + PAGE_SPARE;
  localparam int PAGES_PER_BLOCK = 256;
  localparam int BLOCK_BYTES     = PAGE_BYTES * PAGES_PER_BLOCK;
  localparam int OFS_HALF        = PAGE_DATA / 2;
  localparam int OFS_SPARE       = PAGE_DATA;

  localparam logic [7:0] CMD_READ_A   = 8'h00;
  localparam logic [7:0] CMD_READ_B   = 8'h01;
  localparam logic [7:0] CMD_READ_C   = 8'h50;
  localparam logic [7:0] CMD_IDLE     = 8'hFF;
  localparam logic [7:0] READ_LIMIT   = 8'h50;
  localparam logic [7:0] STATUS_BYTE  = 8'hC0;

  typedef enum logic [1:0] {
    WIN_DATA = 2'd0,
    WIN_CMD  = 2'd1,
    WIN_ADDR = 2'd2,
    WIN_NONE = 2'd3
  } win_e;

  function automatic logic [7:0] keep_known(input logic [7:0] c);
    case (c)
      8'h00, 8'h01, 8'h50, 8'h90, 8'hFF,
      8'h80, 8'h60, 8'h70, 8'h10, 8'hD0: keep_known = c;
      default:                           keep_known = CMD_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/nqf_addr_seq.sv
module nqf_addr_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic       addr_we,
  output logic [1:0] step,
  output logic       step_live
);
  localparam logic [1:0] LAST = 2'd3;

  always_ff @(posedge clk) begin
    if (!rst_n)                        step <= '0;
    else if (cmd_we)                   step <= '0;
    else if (addr_we && step != LAST)  step <= step + 2'd1;
  end

  assign step_live = (step != LAST);
endmodule

// File: rtl/nqf_lane_ctrl.sv
module nqf_lane_ctrl
  import nqf_pkg::*;
#(
  parameter int PTR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_byte,
  input  logic             addr_we,
  input  logic [1:0]       addr_step,
  input  logic [7:0]       addr_byte,
  input  logic             rd_adv,
  output logic             reading,
  output logic [PTR_W-1:0] ptr
);
  logic [7:0]       cmd_q;
  logic [PTR_W-1:0] base_q;
  logic [PTR_W-1:0] off_q;
  logic [7:0]       cmd_new;
  logic [PTR_W-1:0] byte_ext;

  assign cmd_new  = keep_known(cmd_byte);
  assign byte_ext = PTR_W'(addr_byte);
  assign reading  = (cmd_q <= READ_LIMIT);
  assign ptr      = base_q + off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= CMD_IDLE;
    end else if (cmd_we) begin
      cmd_q <= cmd_new;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (cmd_we) begin
      case (cmd_new)
        CMD_READ_A: off_q <= '0;
        CMD_READ_B: off_q <= PTR_W'(OFS_HALF);
        CMD_READ_C: off_q <= PTR_W'(OFS_SPARE);
        default:    off_q <= off_q;
      endcase
    end else if (rd_adv && reading) begin
      off_q <= off_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (addr_we) begin
      case (addr_step)
        2'd0:    base_q <= byte_ext;
        2'd1:    base_q <= base_q + byte_ext * PTR_W'(PAGE_BYTES);
        2'd2:    base_q <= base_q + byte_ext * PTR_W'(BLOCK_BYTES);
        default: base_q <= base_q;
      endcase
    end
  end
endmodule

// File: rtl/nqf_lane_store.sv
module nqf_lane_store #(
  parameter int DEPTH = 1056,
  parameter int PTR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [7:0]       rd_data
);
  logic [7:0]       mem [DEPTH];
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_fold;

  assign rd_idx  = IDX_W'(rd_ptr % PTR_W'(DEPTH));
  assign wr_fold = IDX_W'(PTR_W'(wr_idx) % PTR_W'(DEPTH));
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_fold] <= wr_data;
  end
endmodule

// File: rtl/nand_quad_model.sv
module nand_quad_model
  import nqf_pkg::*;
#(
  parameter int DEPTH = 1056,
  parameter int PTR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hreq_valid,
  output logic              hreq_ready,
  input  logic              hreq_write,
  input  logic [1:0]        hreq_win,
  input  logic [31:0]       hreq_wdata,
  output logic              hrsp_valid,
  input  logic              hrsp_ready,
  output logic [31:0]       hrsp_data,
  input  logic              pre_we,
  input  logic [1:0]        pre_lane,
  input  logic [IDX_W-1:0]  pre_addr,
  input  logic [7:0]        pre_data
);
  logic        accept;
  logic        cmd_we;
  logic        addr_we;
  logic        data_rd;
  logic        any_rd;
  logic [1:0]  step;
  logic        step_live;
  logic [31:0] packed_word;

  assign hreq_ready = !hrsp_valid;
  assign accept     = hreq_valid && hreq_ready;
  assign cmd_we     = accept && hreq_write && (win_e'(hreq_win) == WIN_CMD);
  assign addr_we    = accept && hreq_write && (win_e'(hreq_win) == WIN_ADDR) && step_live;
  assign any_rd     = accept && !hreq_write;
  assign data_rd    = any_rd && (win_e'(hreq_win) == WIN_DATA);

  nqf_addr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .addr_we   (addr_we),
    .step      (step),
    .step_live (step_live)
  );

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    logic             reading;
    logic [PTR_W-1:0] ptr;
    logic [7:0]       rd_byte;

    nqf_lane_ctrl #(.PTR_W(PTR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_we    (cmd_we),
      .cmd_byte  (hreq_wdata[8*c +: 8]),
      .addr_we   (addr_we),
      .addr_step (step),
      .addr_byte (hreq_wdata[8*c +: 8]),
      .rd_adv    (data_rd),
      .reading   (reading),
      .ptr       (ptr)
    );

    nqf_lane_store #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
      .clk     (clk),
      .wr_en   (pre_we && (pre_lane == LANE_W'(c))),
      .wr_idx  (pre_addr),
      .wr_data (pre_data),
      .rd_ptr  (ptr),
      .rd_data (rd_byte)
    );

    assign packed_word[8*c +: 8] = reading ? rd_byte : STATUS_BYTE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hrsp_valid <= 1'b0;
      hrsp_data  <= '0;
    end else if (any_rd) begin
      hrsp_valid <= 1'b1;
      hrsp_data  <= data_rd ? packed_word : 32'h0;
    end else if (hrsp_valid && hrsp_ready) begin
      hrsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nqf_checker.sv
module nqf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        hreq_valid,
  input logic        hreq_ready,
  input logic        hreq_write,
  input logic [1:0]  hreq_win,
  input logic        hrsp_valid,
  input logic        hrsp_ready,
  input logic [31:0] hrsp_data
);
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hrsp_valid && !hrsp_ready |=> hrsp_valid && $stable(hrsp_data)); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    hrsp_valid |-> !hreq_ready); // R8
  AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid && hreq_ready && !hreq_write |=> hrsp_valid); // R8
  AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hrsp_valid) |-> $past(hreq_valid && hreq_ready && !hreq_write)); // R8
  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid && hreq_ready && hreq_write |=> !hrsp_valid); // R9
  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hreq_valid && hreq_ready && !hreq_write && hreq_win != 2'd0 |=> hrsp_data == 32'h0); // R9
endmodule

bind nand_quad_model nqf_checker u_nqf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .hreq_valid (hreq_valid),
  .hreq_ready (hreq_ready),
  .hreq_write (hreq_write),
  .hreq_win   (hreq_win),
  .hrsp_valid (hrsp_valid),
  .hrsp_ready (hrsp_ready),
  .hrsp_data  (hrsp_data)
);

// File: tb/nand_quad_model_bench.sv
module nand_quad_model_bench;
  localparam int DEPTH = 1056;
  localparam int IDX_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              hreq_valid = 1'b0;
  logic              hreq_ready;
  logic              hreq_write = 1'b0;
  logic [1:0]        hreq_win = 2'd0;
  logic [31:0]       hreq_wdata = '0;
  logic              hrsp_valid;
  logic              hrsp_ready = 1'b1;
  logic [31:0]       hrsp_data;
  logic              pre_we = 1'b0;
  logic [1:0]        pre_lane = '0;
  logic [IDX_W-1:0]  pre_addr = '0;
  logic [7:0]        pre_data = '0;

  always #4 clk = ~clk;

  nand_quad_model #(.DEPTH(DEPTH)) u_nand_quad_model (.*);

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  logic [31:0] got;

  // behavioural reference
  int          ref_mem [4][DEPTH];
  int          ref_cmd [4];
  longint      ref_base[4];
  longint      ref_off [4];
  int          ref_step;
  bit          exp_valid;
  logic [31:0] exp_data;

  function automatic int pat(int lane, int a);
    return (a * 13 + lane * 71 + a / 256) & 255;
  endfunction

  function automatic bit known(int c);
    return c == 'h00 || c == 'h01 || c == 'h50 || c == 'h90 || c == 'hFF ||
           c == 'h80 || c == 'h60 || c == 'h70 || c == 'h10 || c == 'hD0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < 4; l++) begin
        ref_cmd[l] = 'hFF; ref_base[l] = 0; ref_off[l] = 0;
      end
      ref_step = 0; exp_valid = 0; exp_data = 0;
    end else begin
      bit acc;
      acc = hreq_valid && !exp_valid;
      if (pre_we) ref_mem[pre_lane][pre_addr] = pre_data;
      if (exp_valid && hrsp_ready) exp_valid = 0;
      if (acc && hreq_write && hreq_win == 2'd1) begin
        for (int l = 0; l < 4; l++) begin
          int c;
          c = (hreq_wdata >> (8 * l)) & 255;
          if (!known(c)) c = 'hFF;
          ref_cmd[l] = c;
          if (c == 'h00) ref_off[l] = 0;
          if (c == 'h01) ref_off[l] = 256;
          if (c == 'h50) ref_off[l] = 512;
        end
        ref_step = 0;
      end else if (acc && hreq_write && hreq_win == 2'd2 && ref_step < 3) begin
        for (int l = 0; l < 4; l++) begin
          longint b;
          b = (hreq_wdata >> (8 * l)) & 255;
          if (ref_step == 0) ref_base[l] = b;
          if (ref_step == 1) ref_base[l] += b * 528;
          if (ref_step == 2) ref_base[l] += b * 528 * 256;
        end
        ref_step++;
      end else if (acc && !hreq_write) begin
        exp_valid = 1;
        exp_data  = 0;
        if (hreq_win == 2'd0) begin
          for (int l = 0; l < 4; l++) begin
            int v;
            if (ref_cmd[l] <= 'h50) begin
              v = ref_mem[l][int'((ref_base[l] + ref_off[l]) % DEPTH)];
              ref_off[l]++;
            end else v = 'hC0;
            exp_data[8*l +: 8] = 8'(v);
          end
        end
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      n_checks++;
      if (hrsp_valid !== exp_valid || hreq_ready !== !exp_valid ||
          (exp_valid && hrsp_data !== exp_data)) begin
        n_fail++;
        $display("FAIL %s cycle compare: valid=%0b ready=%0b data=%08h expected valid=%0b data=%08h",
                 cur_req, hrsp_valid, hreq_ready, hrsp_data, exp_valid, exp_data);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic req(bit wr, logic [1:0] win, logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    hreq_valid = 1'b1; hreq_write = wr; hreq_win = win; hreq_wdata = d;
    while (!hreq_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    hreq_valid = 1'b0;
    rd = hrsp_data;
  endtask

  task automatic wr(logic [1:0] win, logic [31:0] d);
    logic [31:0] dummy;
    req(1'b1, win, d, dummy);
  endtask

  task automatic rd(logic [1:0] win, output logic [31:0] v);
    req(1'b0, win, 32'h0, v);
  endtask

  function automatic logic [31:0] pk(int a0, int a1, int a2, int a3);
    return {8'(pat(3, a3 % DEPTH)), 8'(pat(2, a2 % DEPTH)),
            8'(pat(1, a1 % DEPTH)), 8'(pat(0, a0 % DEPTH))};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", {31'b0, hrsp_valid}, 32'h0);
    chk("R1", {31'b0, hreq_ready}, 32'h1);
    // R10 preload all lanes
    for (int l = 0; l < 4; l++) begin
      for (int a = 0; a < DEPTH; a++) begin
        @(negedge clk);
        pre_we = 1'b1; pre_lane = 2'(l); pre_addr = IDX_W'(a); pre_data = 8'(pat(l, a));
      end
    end
    @(negedge clk);
    pre_we = 1'b0;
    rd(2'd0, got); chk("R1", got, 32'hC0C0C0C0);

    cur_req = "R2";
    wr(2'd1, 32'h00000000);
    wr(2'd2, 32'h05050505); wr(2'd2, 32'h0); wr(2'd2, 32'h0);
    rd(2'd0, got); chk("R2", got, pk(5, 5, 5, 5));
    rd(2'd0, got); chk("R6", got, pk(6, 6, 6, 6));

    cur_req = "R5";
    wr(2'd1, 32'h70500100);
    wr(2'd2, 32'h02020202); wr(2'd2, 32'h01010101);
    rd(2'd0, got);
    chk("R2", got, {8'hC0, 8'(pat(2, 2 + 528 + 512)), 8'(pat(1, 2 + 528 + 256)), 8'(pat(0, 2 + 528))});
    rd(2'd0, got);
    chk("R4", got, {8'hC0, 8'(pat(2, 2 + 528 + 513)), 8'(pat(1, 2 + 528 + 257)), 8'(pat(0, 2 + 529))});

    cur_req = "R3";
    wr(2'd1, 32'h0); wr(2'd2, 32'h0A0A0A0A);
    rd(2'd0, got); chk("R3", got, pk(10, 10, 10, 10));
    wr(2'd1, 32'h10101010);
    rd(2'd0, got); chk("R3", got, pk(11, 11, 11, 11));
    wr(2'd1, 32'h42424242);
    rd(2'd0, got); chk("R3", got, 32'hC0C0C0C0);
    rd(2'd0, got); chk("R4", got, 32'hC0C0C0C0);
    wr(2'd1, 32'h10101010);
    rd(2'd0, got); chk("R4", got, pk(12, 12, 12, 12));

    cur_req = "R5";
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h01010101); wr(2'd2, 32'h0); wr(2'd2, 32'h0); wr(2'd2, 32'h05050505);
    rd(2'd0, got); chk("R5", got, pk(1, 1, 1, 1));
    wr(2'd1, 32'h0); wr(2'd2, 32'h03030303);
    rd(2'd0, got); chk("R5", got, pk(3, 3, 3, 3));

    cur_req = "R7";
    wr(2'd1, 32'h50505050);
    wr(2'd2, 32'hFFFFFFFF); wr(2'd2, 32'h01010101);
    rd(2'd0, got); chk("R7", got, pk(239, 239, 239, 239));
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h07070707); wr(2'd2, 32'h03030303); wr(2'd2, 32'h02020202);
    rd(2'd0, got); chk("R7", got, pk(535, 535, 535, 535));

    cur_req = "R8";
    @(negedge clk); hrsp_ready = 1'b0;
    rd(2'd0, got);
    repeat (3) @(negedge clk);
    chk("R8", {31'b0, hreq_ready}, 32'h0);
    chk("R8", hrsp_data, pk(536, 536, 536, 536));
    hrsp_ready = 1'b1;
    @(negedge clk);
    chk("R8", {31'b0, hrsp_valid}, 32'h0);

    cur_req = "R9";
    rd(2'd1, got); chk("R9", got, 32'h0);
    rd(2'd2, got); chk("R9", got, 32'h0);
    wr(2'd0, 32'h01010101); wr(2'd3, 32'h0);
    rd(2'd0, got); chk("R9", got, pk(537, 537, 537, 537));

    cur_req = "R10";
    @(negedge clk);
    pre_we = 1'b1; pre_lane = 2'd2; pre_addr = IDX_W'(538); pre_data = 8'h5A;
    @(negedge clk);
    pre_we = 1'b0;
    rd(2'd0, got);
    chk("R10", got, {8'(pat(3, 538)), 8'h5A, 8'(pat(1, 538)), 8'(pat(0, 538))});

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule